// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block keeps the fault-confinement state of a CAN controller. Two error counters, one for transmit-side faults and one for receive-side faults, move up on detected errors and down on frames that complete cleanly. The warning, error-passive and bus-off flags are read from those counters against fixed thresholds. The bit-level engine reports events to the block as single-cycle pulses: an error with its type and direction, a clean transmission, a clean reception, and a recovery condition seen while the node is off the bus.

A three-bit field beside the counters records the type of the most recent error. Software can write the field through a small write port. Its usual move is to write the value that hardware never produces, so that a later hardware update is easy to spot. All state sits in registers reset asynchronously. The flags are derived from the registered counters, so every output is stable one clock edge after the event that caused it.

Top module: `can_fault_tracker`

## Requirements
- R1: While reset is asserted and right after it is released, both counters, all three flags and the last-error field read 0.
- R2: A legal error pulse with err_on_tx=1 adds 8 to the transmit counter. A tx_done pulse subtracts 1, and the counter never goes below 0. If both arrive in the same cycle, only the error is applied.
- R3: A legal error pulse with err_on_tx=0 adds 1 to the receive counter, which holds at 255 instead of wrapping. An rx_done pulse subtracts 1, never going below 0. If both arrive in the same cycle, only the error is applied.
- R4: warn_flag is 1 exactly when either counter is 96 or more.
- R5: passive_flag is 1 exactly when either counter is above 127.
- R6: busoff_flag is 1 exactly when the transmit counter is above 255. While it is set, transmit errors and tx_done leave the transmit counter unchanged.
- R7: A bus_recover pulse while busoff_flag is set clears both counters and the flag, and leaves the last-error field unchanged. A bus_recover pulse while busoff_flag is clear has no effect.
- R8: A legal error pulse loads its type into last_code. The encodings are 1 stuff, 2 form, 3 acknowledgment, 4 bit-recessive, 5 bit-dominant and 6 CRC.
- R9: A tx_done or rx_done pulse with no legal error in the same cycle sets last_code to 0 (no error).
- R10: sw_we writes sw_code, including 7, into last_code. A legal error or a clean-frame pulse in the same cycle takes precedence over the write.
- R11: An error pulse whose type is 0 or 7 is dropped: it changes neither counter nor last_code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_valid | input | 1 | Error detected pulse |
| err_kind | input | 3 | Type of the detected error (R8 encodings) |
| err_on_tx | input | 1 | 1: the error occurred while transmitting; 0: while receiving |
| tx_done | input | 1 | Frame transmitted without error |
| rx_done | input | 1 | Frame received without error |
| bus_recover | input | 1 | Recovery condition met while off the bus |
| sw_we | input | 1 | Software write strobe for the last-error field |
| sw_code | input | 3 | Value written by software |
| tx_errcnt | output | 9 | Transmit error counter |
| rx_errcnt | output | 8 | Receive error counter |
| warn_flag | output | 1 | Warning level reached |
| passive_flag | output | 1 | Error-passive level reached |
| busoff_flag | output | 1 | Node is off the bus |
| last_code | output | 3 | Type of the most recent error |

## Verification
Two things can land on the last-error field in the same cycle: a software write and a hardware update, which is either an error capture or a clean-frame clear. The bench provokes this by pulsing sw_we together with a legal error, and again together with tx_done. In both cases it expects the hardware value on the next edge. It also pairs an error with a clean frame on the same counter and expects only the increment to be applied. The bench judges these cases against its own event model.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;

   typedef enum logic [2:0] {
      FC_NONE    = 3'd0,
      FC_STUFF   = 3'd1,
      FC_FORM    = 3'd2,
      FC_ACK     = 3'd3,
      FC_BIT_REC = 3'd4,
      FC_BIT_DOM = 3'd5,
      FC_CRC     = 3'd6,
      FC_SW_MARK = 3'd7
   } fault_code_e;

   // A type the bit engine may legally report
   function automatic logic is_hw_code(input logic [2:0] k);
      return (k != 3'(FC_NONE)) && (k != 3'(FC_SW_MARK));
   endfunction

endpackage

// File: rtl/can_err_counter.sv
module can_err_counter #(
   parameter int W        = 8,
   parameter int STEP     = 1,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         hold,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] count
);

   if (W < 2 || W > 16) begin : g_bad_w
      $error("can_err_counter: W out of range");
   end
   if (STEP < 1 || STEP >= (1 << W)) begin : g_bad_step
      $error("can_err_counter: STEP out of range");
   end

   logic [W-1:0] count_q;
   logic [W-1:0] count_d;
   logic [W-1:0] up_val;

   if (SATURATE) begin : g_sat
      logic [W:0] wide;
      assign wide   = {1'b0, count_q} + (W+1)'(STEP);
      assign up_val = wide[W] ? {W{1'b1}} : wide[W-1:0];
   end else begin : g_wrap
      // Headroom is guaranteed by the instantiating block
      assign up_val = count_q + W'(STEP);
   end

   always_comb begin
      count_d = count_q;
      if (clr) begin
         count_d = '0;
      end else if (!hold) begin
         if (inc) begin
            count_d = up_val;
         end else if (dec && (count_q != '0)) begin
            count_d = count_q - W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else begin
         count_q <= count_d;
      end
   end

   assign count = count_q;

endmodule

// File: rtl/can_flag_eval.sv
module can_flag_eval #(
   parameter int TX_W          = 9,
   parameter int RX_W          = 8,
   parameter int WARN_AT       = 96,
   parameter int PASSIVE_ABOVE = 127,
   parameter int OFF_ABOVE     = 255
) (
   input  logic [TX_W-1:0] tx_cnt,
   input  logic [RX_W-1:0] rx_cnt,
   output logic            warn,
   output logic            passive,
   output logic            off
);

   if (WARN_AT >= (1 << RX_W) || PASSIVE_ABOVE >= (1 << RX_W)) begin : g_bad_rx_thr
      $error("can_flag_eval: receive thresholds exceed counter range");
   end
   if (OFF_ABOVE >= (1 << TX_W) - 1) begin : g_bad_off
      $error("can_flag_eval: bus-off threshold exceeds counter range");
   end

   localparam logic [TX_W-1:0] TX_WARN = TX_W'(WARN_AT);
   localparam logic [RX_W-1:0] RX_WARN = RX_W'(WARN_AT);
   localparam logic [TX_W-1:0] TX_PASV = TX_W'(PASSIVE_ABOVE);
   localparam logic [RX_W-1:0] RX_PASV = RX_W'(PASSIVE_ABOVE);
   localparam logic [TX_W-1:0] TX_OFF  = TX_W'(OFF_ABOVE);

   assign warn    = (tx_cnt >= TX_WARN) || (rx_cnt >= RX_WARN);
   assign passive = (tx_cnt >  TX_PASV) || (rx_cnt >  RX_PASV);
   assign off     = (tx_cnt >  TX_OFF);

endmodule

// File: rtl/can_code_reg.sv
module can_code_reg
   import can_fault_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hw_err,
   input  logic [2:0] hw_kind,
   input  logic       frame_ok,
   input  logic       sw_we,
   input  logic [2:0] sw_code,
   output logic [2:0] code
);

   fault_code_e code_q;
   fault_code_e code_d;

   // Hardware capture outranks clean-frame clear, which outranks software
   always_comb begin
      code_d = code_q;
      if (hw_err) begin
         code_d = fault_code_e'(hw_kind);
      end else if (frame_ok) begin
         code_d = FC_NONE;
      end else if (sw_we) begin
         code_d = fault_code_e'(sw_code);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= FC_NONE;
      end else begin
         code_q <= code_d;
      end
   end

   assign code = code_q;

endmodule

// File: rtl/can_fault_tracker.sv
module can_fault_tracker
   import can_fault_pkg::*;
#(
   parameter int TX_W          = 9,
   parameter int RX_W          = 8,
   parameter int TX_STEP       = 8,
   parameter int RX_STEP       = 1,
   parameter int WARN_AT       = 96,
   parameter int PASSIVE_ABOVE = 127,
   parameter int OFF_ABOVE     = 255
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            err_valid,
   input  logic [2:0]      err_kind,
   input  logic            err_on_tx,
   input  logic            tx_done,
   input  logic            rx_done,
   input  logic            bus_recover,
   input  logic            sw_we,
   input  logic [2:0]      sw_code,
   output logic [TX_W-1:0] tx_errcnt,
   output logic [RX_W-1:0] rx_errcnt,
   output logic            warn_flag,
   output logic            passive_flag,
   output logic            busoff_flag,
   output logic [2:0]      last_code
);

   // The transmit counter must hold the largest value reachable from the
   // last count that is not yet bus-off, without wrapping
   if (OFF_ABOVE + TX_STEP > (1 << TX_W) - 1) begin : g_bad_tx_room
      $error("can_fault_tracker: TX_W too narrow for OFF_ABOVE + TX_STEP");
   end

   logic err_legal;
   logic tx_hit;
   logic rx_hit;
   logic off_now;
   logic recover_clr;

   assign err_legal   = err_valid && is_hw_code(err_kind);
   assign tx_hit      = err_legal && err_on_tx;
   assign rx_hit      = err_legal && !err_on_tx;
   assign recover_clr = bus_recover && off_now;

   can_err_counter #(
      .W        (TX_W),
      .STEP     (TX_STEP),
      .SATURATE (1'b0)
   ) u_tx_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (recover_clr),
      .hold  (off_now),
      .inc   (tx_hit),
      .dec   (tx_done),
      .count (tx_errcnt)
   );

   can_err_counter #(
      .W        (RX_W),
      .STEP     (RX_STEP),
      .SATURATE (1'b1)
   ) u_rx_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (recover_clr),
      .hold  (1'b0),
      .inc   (rx_hit),
      .dec   (rx_done),
      .count (rx_errcnt)
   );

   can_flag_eval #(
      .TX_W          (TX_W),
      .RX_W          (RX_W),
      .WARN_AT       (WARN_AT),
      .PASSIVE_ABOVE (PASSIVE_ABOVE),
      .OFF_ABOVE     (OFF_ABOVE)
   ) u_flags (
      .tx_cnt  (tx_errcnt),
      .rx_cnt  (rx_errcnt),
      .warn    (warn_flag),
      .passive (passive_flag),
      .off     (off_now)
   );

   assign busoff_flag = off_now;

   can_code_reg u_code (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_err   (err_legal),
      .hw_kind  (err_kind),
      .frame_ok (tx_done || rx_done),
      .sw_we    (sw_we),
      .sw_code  (sw_code),
      .code     (last_code)
   );

endmodule

// File: rtl/can_fault_tracker_chk.sv
module can_fault_tracker_chk #(
   parameter int TX_W          = 9,
   parameter int RX_W          = 8,
   parameter int TX_STEP       = 8,
   parameter int WARN_AT       = 96,
   parameter int PASSIVE_ABOVE = 127,
   parameter int OFF_ABOVE     = 255
) (
   input logic            clk,
   input logic            rst_n,
   input logic            err_valid,
   input logic [2:0]      err_kind,
   input logic            err_on_tx,
   input logic            tx_done,
   input logic            rx_done,
   input logic            bus_recover,
   input logic            sw_we,
   input logic [2:0]      sw_code,
   input logic [TX_W-1:0] tx_errcnt,
   input logic [RX_W-1:0] rx_errcnt,
   input logic            warn_flag,
   input logic            passive_flag,
   input logic            busoff_flag,
   input logic [2:0]      last_code
);

   localparam logic [TX_W-1:0] C_TX_WARN = TX_W'(WARN_AT);
   localparam logic [RX_W-1:0] C_RX_WARN = RX_W'(WARN_AT);
   localparam logic [TX_W-1:0] C_TX_PASV = TX_W'(PASSIVE_ABOVE);
   localparam logic [RX_W-1:0] C_RX_PASV = RX_W'(PASSIVE_ABOVE);
   localparam logic [TX_W-1:0] C_TX_OFF  = TX_W'(OFF_ABOVE);

   logic legal;
   assign legal = err_valid && (err_kind != 3'd0) && (err_kind != 3'd7);

   a_r2_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (legal && err_on_tx && !busoff_flag) |=> (tx_errcnt == $past(tx_errcnt) + TX_W'(TX_STEP)));

   a_r3_rx_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
      (legal && !err_on_tx && (rx_errcnt == {RX_W{1'b1}}) && !busoff_flag) |=> (rx_errcnt == {RX_W{1'b1}}));

   a_r3_rx_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!legal && rx_done && (rx_errcnt != '0) && !(bus_recover && busoff_flag))
         |=> (rx_errcnt == $past(rx_errcnt) - RX_W'(1)));

   a_r4_warn: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_errcnt >= C_TX_WARN) || (rx_errcnt >= C_RX_WARN)) |-> warn_flag);

   a_r5_passive: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_errcnt > C_TX_PASV) || (rx_errcnt > C_RX_PASV)) |-> passive_flag);

   a_r6_enter: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_errcnt > C_TX_OFF) |-> busoff_flag);

   a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busoff_flag && !bus_recover) |=> ($stable(tx_errcnt) && busoff_flag));

   a_r7_recover: assert property (@(posedge clk) disable iff (!rst_n)
      (busoff_flag && bus_recover) |=> ((tx_errcnt == '0) && (rx_errcnt == '0) && !busoff_flag && $stable(last_code)));

   a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      legal |=> (last_code == $past(err_kind)));

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!legal && (tx_done || rx_done)) |=> (last_code == 3'd0));

   a_r10_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !legal && !tx_done && !rx_done) |=> (last_code == $past(sw_code)));

   a_r10_mark_source: assert property (@(posedge clk) disable iff (!rst_n)
      ((last_code == 3'd7) && ($past(last_code) != 3'd7)) |-> $past(sw_we));

endmodule

bind can_fault_tracker can_fault_tracker_chk #(
   .TX_W          (TX_W),
   .RX_W          (RX_W),
   .TX_STEP       (TX_STEP),
   .WARN_AT       (WARN_AT),
   .PASSIVE_ABOVE (PASSIVE_ABOVE),
   .OFF_ABOVE     (OFF_ABOVE)
) u_chk (.*);

// File: tb/can_fault_tracker_tb.sv
module can_fault_tracker_tb;

   logic       clk;
   logic       rst_n;
   logic       err_valid;
   logic [2:0] err_kind;
   logic       err_on_tx;
   logic       tx_done;
   logic       rx_done;
   logic       bus_recover;
   logic       sw_we;
   logic [2:0] sw_code;
   logic [8:0] tx_errcnt;
   logic [7:0] rx_errcnt;
   logic       warn_flag;
   logic       passive_flag;
   logic       busoff_flag;
   logic [2:0] last_code;

   can_fault_tracker u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .err_valid    (err_valid),
      .err_kind     (err_kind),
      .err_on_tx    (err_on_tx),
      .tx_done      (tx_done),
      .rx_done      (rx_done),
      .bus_recover  (bus_recover),
      .sw_we        (sw_we),
      .sw_code      (sw_code),
      .tx_errcnt    (tx_errcnt),
      .rx_errcnt    (rx_errcnt),
      .warn_flag    (warn_flag),
      .passive_flag (passive_flag),
      .busoff_flag  (busoff_flag),
      .last_code    (last_code)
   );

   // 125 MHz
   initial clk = 1'b0;
   always #4 clk = ~clk;

   typedef struct {
      logic [8:0] tx;
      logic [7:0] rx;
      logic       w;
      logic       p;
      logic       b;
      logic [2:0] code;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;

   // Reference state built from the requirements
   int         m_tx = 0;
   int         m_rx = 0;
   logic [2:0] m_code = 3'd0;

   function automatic exp_t snap(input string tag);
      exp_t e;
      e.tx   = 9'(m_tx);
      e.rx   = 8'(m_rx);
      e.w    = (m_tx >= 96) || (m_rx >= 96);
      e.p    = (m_tx > 127) || (m_rx > 127);
      e.b    = (m_tx > 255);
      e.code = m_code;
      e.tag  = tag;
      return e;
   endfunction

   task automatic step(input bit ev, input logic [2:0] kind, input bit on_tx,
                       input bit txd, input bit rxd, input bit rcv,
                       input bit we, input logic [2:0] wc, input string tag);
      bit legal;
      bit off;
      @(negedge clk);
      err_valid   = ev;
      err_kind    = kind;
      err_on_tx   = on_tx;
      tx_done     = txd;
      rx_done     = rxd;
      bus_recover = rcv;
      sw_we       = we;
      sw_code     = wc;
      legal = ev && (kind != 3'd0) && (kind != 3'd7);
      off   = (m_tx > 255);
      if (rcv && off) begin
         m_tx = 0;
         m_rx = 0;
      end else begin
         if (!off) begin
            if (legal && on_tx) m_tx = m_tx + 8;
            else if (txd && m_tx > 0) m_tx = m_tx - 1;
         end
         if (legal && !on_tx) m_rx = (m_rx == 255) ? 255 : m_rx + 1;
         else if (rxd && m_rx > 0) m_rx = m_rx - 1;
      end
      if (legal) m_code = kind;
      else if (txd || rxd) m_code = 3'd0;
      else if (we) m_code = wc;
      q.push_back(snap(tag));
   endtask

   task automatic idle(input string tag);
      step(0, 3'd0, 0, 0, 0, 0, 0, 3'd0, tag);
   endtask
   task automatic tx_err(input logic [2:0] k, input string tag);
      step(1, k, 1, 0, 0, 0, 0, 3'd0, tag);
   endtask
   task automatic rx_err(input logic [2:0] k, input string tag);
      step(1, k, 0, 0, 0, 0, 0, 3'd0, tag);
   endtask
   task automatic tx_ok(input string tag);
      step(0, 3'd0, 0, 1, 0, 0, 0, 3'd0, tag);
   endtask
   task automatic rx_ok(input string tag);
      step(0, 3'd0, 0, 0, 1, 0, 0, 3'd0, tag);
   endtask

   // Monitor: outputs settle one edge after the driven cycle
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (tx_errcnt !== e.tx || rx_errcnt !== e.rx || warn_flag !== e.w ||
                passive_flag !== e.p || busoff_flag !== e.b || last_code !== e.code) begin
               n_fail++;
               $display("FAIL %s: actual tx=%0d rx=%0d w=%0b p=%0b b=%0b code=%0d expected tx=%0d rx=%0d w=%0b p=%0b b=%0b code=%0d",
                        e.tag, tx_errcnt, rx_errcnt, warn_flag, passive_flag, busoff_flag, last_code,
                        e.tx, e.rx, e.w, e.p, e.b, e.code);
            end
         end
      end
   end

   // Watchdog
   initial begin
      #(8 * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual run still busy expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      err_valid = 0; err_kind = 0; err_on_tx = 0; tx_done = 0;
      rx_done = 0; bus_recover = 0; sw_we = 0; sw_code = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_checks++;
      if (tx_errcnt !== 0 || rx_errcnt !== 0 || warn_flag !== 0 || passive_flag !== 0 ||
          busoff_flag !== 0 || last_code !== 0) begin
         n_fail++;
         $display("FAIL R1 in reset: actual tx=%0d rx=%0d flags=%b%b%b code=%0d expected all 0",
                  tx_errcnt, rx_errcnt, warn_flag, passive_flag, busoff_flag, last_code);
      end
      rst_n = 1'b1;
      idle("R1 after release");

      // R2: transmit counter moves
      for (int i = 0; i < 3; i++) tx_err(3'd1, "R2 tx error +8");
      tx_ok("R2 tx ok -1");
      step(1, 3'd2, 1, 1, 0, 0, 0, 3'd0, "R2 error beats tx ok");
      for (int i = 0; i < 32; i++) tx_ok("R2 tx ok down to floor");

      // R3: receive counter moves
      rx_err(3'd3, "R3 rx error +1");
      rx_ok("R3 rx ok -1");
      rx_ok("R3 rx ok at 0");
      step(1, 3'd4, 0, 0, 1, 0, 0, 3'd0, "R3 error beats rx ok");
      rx_ok("R3 back to 0");

      // R4/R5 via receive counter, R3 saturation
      for (int i = 0; i < 95; i++) rx_err(3'd1, "R4 below warn");
      rx_err(3'd1, "R4 rx reaches 96");
      for (int i = 0; i < 31; i++) rx_err(3'd1, "R5 up to 127");
      rx_err(3'd1, "R5 rx passes 127");
      for (int i = 0; i < 127; i++) rx_err(3'd1, "R3 up to 255");
      rx_err(3'd1, "R3 saturate at 255");
      for (int i = 0; i < 255; i++) rx_ok("R4 R5 rx draining");

      // R4/R5/R6 via transmit counter
      for (int i = 0; i < 31; i++) tx_err(3'd5, "R4 R5 tx climbing");
      tx_ok("R6 tx 247");
      tx_err(3'd6, "R6 tx 255 not off");
      tx_err(3'd6, "R6 tx 263 bus-off");
      tx_err(3'd2, "R6 frozen on error");
      tx_ok("R6 frozen on tx ok");
      rx_err(3'd3, "R6 rx still counts");
      step(0, 3'd0, 0, 0, 0, 0, 1, 3'd7, "R10 sw mark during bus-off");

      // R7
      step(0, 3'd0, 0, 0, 0, 1, 0, 3'd0, "R7 recover clears");
      tx_err(3'd1, "R7 setup");
      step(0, 3'd0, 0, 0, 0, 1, 0, 3'd0, "R7 recover ignored");
      for (int i = 0; i < 8; i++) tx_ok("R2 drain");

      // R8: each hardware type
      for (int k = 1; k <= 6; k++) begin
         rx_err(3'(k), "R8 capture type");
         rx_ok("R9 clear");
      end

      // R11: illegal types dropped
      tx_err(3'd3, "R8 set code 3");
      tx_err(3'd0, "R11 type 0 dropped");
      rx_err(3'd7, "R11 type 7 dropped");

      // R10: software writes and same-cycle conflicts
      step(0, 3'd0, 0, 0, 0, 0, 1, 3'd7, "R10 sw writes 7");
      idle("R10 hold 7");
      step(1, 3'd2, 0, 0, 0, 0, 1, 3'd5, "R10 hw error beats sw");
      step(0, 3'd0, 0, 1, 0, 0, 1, 3'd6, "R10 clean frame beats sw");
      step(0, 3'd0, 0, 0, 0, 0, 1, 3'd4, "R10 sw writes 4");
      tx_ok("R9 tx ok clears");
      idle("final");
      idle("final");

      wait (q.size() == 0);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule